// File: doc/BRIEF.md
# Real-Time Clock Counter with Wake Alarm

This block keeps wall-clock time as a 48-bit up-counter that advances once for every pulse of a tick-enable strobe. The strobe is expected at 65536 Hz, which is twice a 32768 Hz crystal, so one second is 2^16 counts. A host reaches the count, a 32-bit alarm value and a control byte through a simple synchronous byte-register bus.

The alarm is compared only against the upper 32 bits of the count, so its resolution is one second. When the alarm matches while the alarm enable is on, the block latches a wake request that asks the system to power up. It does not raise an interrupt. The control byte also holds a sticky "time has been set" flag, which only the power-domain reset clears. Firmware reads this flag to tell whether the time survived a power loss.

A read of the lowest time byte takes a snapshot of the whole count. The other five time bytes then return that snapshot, so a multi-byte read sees one consistent value while the counter keeps running.

Top module: `rtc_wake_core`

## Requirements
- R1: After `pwr_rst` the control byte reads 0x30, the count and the alarm read 0 and `wake_req` is low.
- R2: Each cycle with `tick_en` high and no time-byte write adds one to the 48-bit count, carrying across bytes and wrapping modulo 2^48. With `tick_en` low the count holds.
- R3: A write to address 0x5A+k (k = 0..5, byte 0 least significant) replaces byte k of the count at that clock edge. The count does not advance in that cycle, even when `tick_en` is high.
- R4: A read of 0x5A returns the live low byte and captures bytes 1..5. Reads of 0x5B..0x5F return the captured bytes, not the live count.
- R5: Alarm bytes sit at 0x56..0x59 and map to count bits 16-23, 24-31, 32-39 and 40-47 in that order. They can be written and read back.
- R6: The alarm matches when all 32 alarm bits equal count bits 47..16. Count bits 15..0 do not take part. If control bit 2 (alarm enable) is 1 and the registered count matches, `wake_req` goes high one cycle later and stays high.
- R7: While control bit 2 is 0, a match never raises `wake_req`.
- R8: A write to control (0x53) with data bit 2 = 0 makes `wake_req` low after that edge. This clear takes priority over a match in the same cycle.
- R9: Control bit 0 is sticky. Writing 1 sets it, writing 0 leaves it unchanged, and only `pwr_rst` clears it. Bits 7..1 take the written value directly.
- R10: `osc_bypass` follows control bit 1 and `clkbuf_off` follows control bit 3.
- R11: `bus_rdata` is registered and holds the data of a read the cycle after `bus_re`. It is 0x00 in cycles with no read and for any address other than 0x53, 0x56..0x59 and 0x5A..0x5F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst | input | 1 | Synchronous active-high power-domain reset |
| tick_en | input | 1 | Count-advance strobe (65536 per second) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 8 | Registered read data |
| osc_bypass | output | 1 | Crystal oscillator bypass request |
| clkbuf_off | output | 1 | 32 kHz clock buffer disable |
| wake_req | output | 1 | Latched power-up request from the alarm |

## Verification
The assertions assume that every input holds a known 0 or 1 value at each clock edge after reset. They also assume that `tick_en` may be high in any cycle, including cycles with a bus write, so that the count property has to account for the write priority. The stimulus drives all inputs on the falling edge. In the random phase it never asserts `bus_we` and `bus_re` together and keeps most addresses inside the mapped window 0x53..0x5F. Directed sequences place the count just below an alarm boundary, so that a match, its one-cycle latch and the clear priority are all exercised.

// File: rtl/rtc_wake_pkg.sv
package rtc_wake_pkg;

    localparam int unsigned CNT_BYTES = 6;
    localparam int unsigned ALM_BYTES = 4;

    // Bus map: the byte order inside each window is architectural.
    localparam logic [7:0] ADDR_CTRL = 8'h53;
    localparam logic [7:0] ADDR_ALM0 = 8'h56;
    localparam logic [7:0] ADDR_CNT0 = 8'h5A;

    localparam logic [7:0] CTRL_RESET = 8'h30;

    typedef struct packed {
        logic [3:0] spare;
        logic       clkbuf_off;
        logic       alarm_en;
        logic       osc_bypass;
        logic       set_flag;
    } ctrl_t;

    // Address hit for byte index idx of a window starting at base.
    function automatic logic addr_hit(input logic [7:0] addr,
                                      input logic [7:0] base,
                                      input int unsigned idx);
        return addr == (base + 8'(idx));
    endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
    parameter int unsigned NBYTES = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_en,
    input  logic [NBYTES-1:0]   wr_sel,
    input  logic [7:0]          wr_byte,
    output logic [NBYTES*8-1:0] count
);
    localparam int unsigned W = NBYTES * 8;

    logic [W-1:0] count_nxt;

    always_comb begin
        count_nxt = count;
        if (|wr_sel) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_sel[b]) count_nxt[b*8 +: 8] = wr_byte;
            end
        end else if (tick_en) begin
            count_nxt = count + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= count_nxt;
    end

endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
    parameter int unsigned NBYTES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NBYTES-1:0]   wr_sel,
    input  logic [7:0]          wr_byte,
    input  logic [NBYTES*8-1:0] cmp_val,
    input  logic                arm,
    input  logic                disarm_wr,
    output logic [NBYTES*8-1:0] alarm,
    output logic                wake_req
);
    logic match;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)            alarm[g*8 +: 8] <= 8'h00;
            else if (wr_sel[g]) alarm[g*8 +: 8] <= wr_byte;
        end
    end

    assign match = (alarm == cmp_val);

    always_ff @(posedge clk) begin
        if (rst)                wake_req <= 1'b0;
        else if (disarm_wr)     wake_req <= 1'b0;
        else if (arm && match)  wake_req <= 1'b1;
    end

endmodule

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_wake_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output ctrl_t      ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= ctrl_t'(CTRL_RESET);
        end else if (wr_en) begin
            // The set flag only accumulates ones.
            ctrl <= ctrl_t'({wr_byte[7:1], wr_byte[0] | ctrl.set_flag});
        end
    end

endmodule

// File: rtl/rtc_wake_core.sv
module rtc_wake_core
    import rtc_wake_pkg::*;
#(
    parameter int unsigned NCNT = CNT_BYTES,
    parameter int unsigned NALM = ALM_BYTES
) (
    input  logic       clk,
    input  logic       pwr_rst,
    input  logic       tick_en,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_we,
    input  logic       bus_re,
    output logic [7:0] bus_rdata,
    output logic       osc_bypass,
    output logic       clkbuf_off,
    output logic       wake_req
);
    localparam int unsigned CW = NCNT * 8;
    localparam int unsigned AW = NALM * 8;

    logic [NCNT-1:0] cnt_hit;
    logic [NALM-1:0] alm_hit;
    logic            ctrl_hit;
    logic [CW-1:0]   count;
    logic [AW-1:0]   alarm;
    logic [CW-1:9+0] shadow_unused_guard;
    logic [CW-1:8]   shadow;
    ctrl_t           ctrl;
    logic [7:0]      rd_nxt;
    logic            capture;

    assign shadow_unused_guard = '0;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt_dec
        assign cnt_hit[g] = addr_hit(bus_addr, ADDR_CNT0, g);
    end
    for (genvar g = 0; g < NALM; g++) begin : g_alm_dec
        assign alm_hit[g] = addr_hit(bus_addr, ADDR_ALM0, g);
    end
    assign ctrl_hit = (bus_addr == ADDR_CTRL);

    rtc_time_counter #(.NBYTES(NCNT)) u_counter (
        .clk     (clk),
        .rst     (pwr_rst),
        .tick_en (tick_en),
        .wr_sel  (cnt_hit & {NCNT{bus_we}}),
        .wr_byte (bus_wdata),
        .count   (count)
    );

    rtc_alarm_unit #(.NBYTES(NALM)) u_alarm (
        .clk       (clk),
        .rst       (pwr_rst),
        .wr_sel    (alm_hit & {NALM{bus_we}}),
        .wr_byte   (bus_wdata),
        .cmp_val   (count[CW-1 -: AW]),
        .arm       (ctrl.alarm_en),
        .disarm_wr (bus_we & ctrl_hit & ~bus_wdata[2]),
        .alarm     (alarm),
        .wake_req  (wake_req)
    );

    rtc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (pwr_rst),
        .wr_en   (bus_we & ctrl_hit),
        .wr_byte (bus_wdata),
        .ctrl    (ctrl)
    );

    assign osc_bypass = ctrl.osc_bypass;
    assign clkbuf_off = ctrl.clkbuf_off;

    // Read path: low time byte comes live, the rest from the snapshot.
    assign capture = bus_re & cnt_hit[0];

    always_comb begin
        rd_nxt = 8'h00;
        if (bus_re) begin
            if (ctrl_hit) rd_nxt = ctrl;
            for (int b = 0; b < int'(NALM); b++) begin
                if (alm_hit[b]) rd_nxt = alarm[b*8 +: 8];
            end
            if (cnt_hit[0]) rd_nxt = count[7:0];
            for (int b = 1; b < int'(NCNT); b++) begin
                if (cnt_hit[b]) rd_nxt = shadow[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (pwr_rst) begin
            bus_rdata <= 8'h00;
            shadow    <= '0;
        end else begin
            bus_rdata <= rd_nxt;
            if (capture) shadow <= count[CW-1:8];
        end
    end

endmodule

// File: rtl/rtc_wake_checker.sv
module rtc_wake_checker
    import rtc_wake_pkg::*;
#(
    parameter int unsigned NCNT = CNT_BYTES,
    parameter int unsigned NALM = ALM_BYTES
) (
    input logic            clk,
    input logic            rst,
    input logic            tick_en,
    input logic            bus_we,
    input logic            bus_re,
    input logic [7:0]      bus_addr,
    input logic            wdata_b2,
    input logic [7:0]      bus_rdata,
    input logic [NCNT*8-1:0] count,
    input logic            set_flag,
    input logic            alarm_en,
    input logic            wake_req
);
    logic cnt_win, alm_win, ctl_sel, unmapped;

    assign cnt_win  = (bus_addr >= ADDR_CNT0) && (bus_addr <= ADDR_CNT0 + 8'(NCNT - 1));
    assign alm_win  = (bus_addr >= ADDR_ALM0) && (bus_addr <= ADDR_ALM0 + 8'(NALM - 1));
    assign ctl_sel  = (bus_addr == ADDR_CTRL);
    assign unmapped = !cnt_win && !alm_win && !ctl_sel;

    a_r9_set_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        set_flag |=> set_flag);

    a_r2_tick_advance: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !(bus_we && cnt_win)) |=> count == $past(count) + (NCNT*8)'(1));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !bus_we) |=> $stable(count));

    a_r8_disarm_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_we && ctl_sel && !wdata_b2) |=> !wake_req);

    a_r7_wake_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_req) |-> $past(alarm_en));

    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (!bus_re || unmapped) |=> bus_rdata == 8'h00);

endmodule

bind rtc_wake_core rtc_wake_checker #(.NCNT(NCNT), .NALM(NALM)) u_chk (
    .clk       (clk),
    .rst       (pwr_rst),
    .tick_en   (tick_en),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .wdata_b2  (bus_wdata[2]),
    .bus_rdata (bus_rdata),
    .count     (count),
    .set_flag  (ctrl.set_flag),
    .alarm_en  (ctrl.alarm_en),
    .wake_req  (wake_req)
);

// File: tb/rtc_wake_core_bench.sv
`timescale 1ns/1ps
module rtc_wake_core_bench;

    logic       clk = 1'b0;
    logic       pwr_rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       osc_bypass, clkbuf_off, wake_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Reference state
    logic [47:0] m_cnt, m_shadow;
    logic [31:0] m_alm;
    logic [7:0]  m_ctrl, m_rd;
    logic        m_wake;

    always #4 clk = ~clk;

    rtc_wake_core u_rtc_wake_core (
        .clk(clk), .pwr_rst(pwr_rst), .tick_en(tick_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata), .osc_bypass(osc_bypass),
        .clkbuf_off(clkbuf_off), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic match;
        logic [7:0] rdn;
        if (pwr_rst) begin
            m_cnt = '0; m_shadow = '0; m_alm = '0;
            m_ctrl = 8'h30; m_rd = 8'h00; m_wake = 1'b0;
            return;
        end
        match = (m_alm == m_cnt[47:16]);
        rdn = 8'h00;
        if (bus_re) begin
            if (bus_addr == 8'h53) rdn = m_ctrl;
            else if (bus_addr >= 8'h56 && bus_addr <= 8'h59)
                rdn = m_alm[(bus_addr - 8'h56)*8 +: 8];
            else if (bus_addr == 8'h5A) begin
                rdn = m_cnt[7:0];
                m_shadow = m_cnt;
            end else if (bus_addr >= 8'h5B && bus_addr <= 8'h5F)
                rdn = m_shadow[(bus_addr - 8'h5A)*8 +: 8];
        end
        m_rd = rdn;
        if (bus_we && bus_addr == 8'h53 && !bus_wdata[2]) m_wake = 1'b0;
        else if (m_ctrl[2] && match) m_wake = 1'b1;
        if (bus_we && bus_addr == 8'h53)
            m_ctrl = {bus_wdata[7:1], bus_wdata[0] | m_ctrl[0]};
        if (bus_we && bus_addr >= 8'h56 && bus_addr <= 8'h59)
            m_alm[(bus_addr - 8'h56)*8 +: 8] = bus_wdata;
        if (bus_we && bus_addr >= 8'h5A && bus_addr <= 8'h5F)
            m_cnt[(bus_addr - 8'h5A)*8 +: 8] = bus_wdata;
        else if (tick_en)
            m_cnt = m_cnt + 48'd1;
    endtask

    task automatic cyc(input logic t, input logic w, input logic r,
                       input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        tick_en = t; bus_we = w; bus_re = r; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_step();
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic t);
        cyc(t, 1'b1, 1'b0, a, d);
    endtask

    task automatic rd(input logic [7:0] a, input logic t);
        cyc(t, 1'b0, 1'b1, a, 8'h00);
    endtask

    task automatic idle(input logic t, input int n);
        for (int i = 0; i < n; i++) cyc(t, 1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        pwr_rst = 1'b1;
        idle(1'b0, 3);
        @(negedge clk);
        pwr_rst = 1'b0;
    endtask

    task automatic set_count(input logic [47:0] v);
        for (int k = 0; k < 6; k++) wr(8'h5A + 8'(k), v[k*8 +: 8], 1'b1);
    endtask

    task automatic cmp_model(input string tag);
        chk({tag, " rdata"}, bus_rdata, m_rd);
        chk({tag, " wake"}, wake_req, m_wake);
        chk({tag, " osc"}, osc_bypass, m_ctrl[1]);
        chk({tag, " buf"}, clkbuf_off, m_ctrl[3]);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [47:0] v;
        void'($urandom(32'd2024));
        do_reset();

        // R1 reset values
        rd(8'h53, 1'b0); chk("R1 ctrl reset", bus_rdata, 8'h30);
        chk("R1 wake reset", wake_req, 1'b0);
        rd(8'h5A, 1'b0); chk("R1 count reset", bus_rdata, 8'h00);
        rd(8'h59, 1'b0); chk("R1 alarm reset", bus_rdata, 8'h00);
        idle(1'b0, 1);   chk("R11 no read gives zero", bus_rdata, 8'h00);

        // R3 byte writes win over tick
        set_count(48'h0000_1234_FFFE);
        rd(8'h5A, 1'b0); chk("R3 written low byte", bus_rdata, 8'hFE);
        // R4 snapshot while counting across a carry
        rd(8'h5B, 1'b1); chk("R4 snapshot b1", bus_rdata, 8'hFF);
        rd(8'h5C, 1'b1); chk("R4 snapshot b2", bus_rdata, 8'h34);
        rd(8'h5D, 1'b1); chk("R4 snapshot b3", bus_rdata, 8'h12);
        rd(8'h5E, 1'b1); chk("R4 snapshot b4", bus_rdata, 8'h00);
        rd(8'h5F, 1'b1); chk("R4 snapshot b5", bus_rdata, 8'h00);
        // R2 carry: 0x1234FFFE + 5 = 0x12350003
        rd(8'h5A, 1'b0); chk("R2 counted low byte", bus_rdata, 8'h03);
        rd(8'h5C, 1'b0); chk("R2 carry into byte 2", bus_rdata, 8'h35);
        idle(1'b0, 10);
        rd(8'h5A, 1'b0); chk("R2 hold without tick", bus_rdata, 8'h03);
        set_count(48'hFFFF_FFFF_FFFF);
        idle(1'b1, 1);
        rd(8'h5A, 1'b0); chk("R2 wrap low", bus_rdata, 8'h00);
        rd(8'h5F, 1'b0); chk("R2 wrap high", bus_rdata, 8'h00);

        // R5 alarm byte storage
        wr(8'h56, 8'hA5, 1'b0); wr(8'h57, 8'h5A, 1'b0);
        wr(8'h58, 8'hC3, 1'b0); wr(8'h59, 8'h3C, 1'b0);
        rd(8'h56, 1'b0); chk("R5 alarm b0", bus_rdata, 8'hA5);
        rd(8'h57, 1'b0); chk("R5 alarm b1", bus_rdata, 8'h5A);
        rd(8'h58, 1'b0); chk("R5 alarm b2", bus_rdata, 8'hC3);
        rd(8'h59, 1'b0); chk("R5 alarm b3", bus_rdata, 8'h3C);
        wr(8'h56, 8'h02, 1'b0); wr(8'h57, 8'h00, 1'b0);
        wr(8'h58, 8'h00, 1'b0); wr(8'h59, 8'h00, 1'b0);

        // R7 matching but disabled
        set_count(48'h0000_0001_FFFC);
        idle(1'b1, 12);
        chk("R7 disabled no wake", wake_req, 1'b0);

        // R6 enabled match; low 16 bits play no part
        set_count(48'h0000_0001_FFF0);
        wr(8'h53, 8'h34, 1'b0);
        idle(1'b1, 15); chk("R6 before match", wake_req, 1'b0);
        idle(1'b1, 1);  chk("R6 latch one cycle later", wake_req, 1'b0);
        idle(1'b1, 1);  chk("R6 wake raised", wake_req, 1'b1);
        idle(1'b1, 20); chk("R6 wake stays", wake_req, 1'b1);

        // R8 clear wins over an ongoing match
        wr(8'h53, 8'h30, 1'b1); chk("R8 clear priority", wake_req, 1'b0);
        wr(8'h53, 8'h34, 1'b1); chk("R6 rearm pending", wake_req, 1'b0);
        idle(1'b1, 1);          chk("R6 low bits ignored", wake_req, 1'b1);

        // R9 sticky flag and R10 outputs
        wr(8'h53, 8'h31, 1'b0);
        wr(8'h53, 8'h30, 1'b0);
        rd(8'h53, 1'b0); chk("R9 flag kept after zero write", bus_rdata, 8'h31);
        wr(8'h53, 8'h3A, 1'b0);
        chk("R10 osc bypass", osc_bypass, 1'b1);
        chk("R10 clkbuf off", clkbuf_off, 1'b1);
        rd(8'h53, 1'b0); chk("R9 plain bits", bus_rdata, 8'h3B);
        wr(8'h53, 8'h30, 1'b0);
        chk("R10 osc cleared", osc_bypass, 1'b0);

        // R11 unmapped
        rd(8'h00, 1'b0); chk("R11 unmapped 00", bus_rdata, 8'h00);
        rd(8'h54, 1'b0); chk("R11 unmapped 54", bus_rdata, 8'h00);
        rd(8'h55, 1'b0); chk("R11 unmapped 55", bus_rdata, 8'h00);
        rd(8'h60, 1'b0); chk("R11 unmapped 60", bus_rdata, 8'h00);
        rd(8'hFF, 1'b0); chk("R11 unmapped FF", bus_rdata, 8'h00);

        // R9 only the power reset clears the flag
        do_reset();
        rd(8'h53, 1'b0); chk("R9 reset clears flag", bus_rdata, 8'h30);

        // Random mix against the reference (R2 R3 R4 R5 R6 R8 R11)
        v = {16'h0000, 32'h0003_FFE0};
        set_count(v);
        wr(8'h56, 8'h04, 1'b0);
        for (int i = 0; i < 800; i++) begin
            int unsigned op;
            logic [7:0] a;
            op = $urandom % 10;
            a = ($urandom % 8 == 0) ? 8'($urandom) : 8'h53 + 8'($urandom % 13);
            if (op < 2)      cyc(1'($urandom), 1'b1, 1'b0, a, 8'($urandom));
            else if (op < 6) cyc(1'($urandom), 1'b0, 1'b1, a, 8'h00);
            else             cyc(1'($urandom), 1'b0, 1'b0, a, 8'($urandom));
            cmp_model("R4 R6 R11 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule